// File: doc/BRIEF.md
# Receive Identifier Acceptance Screen

This block sits between a CAN receive path and its receive buffer. It decides, one identifier word at a time, whether a received frame is stored. A set of filter slots is held in registers. Each slot has a mask word, an identifier word and an enable bit. An incoming identifier is accepted if at least one enabled slot matches it. It is also accepted if no slot is enabled at all. An accepted word gives a one-cycle accept pulse, together with the index of the lowest-numbered slot that matched.

Software programs the slots through a simple 32-bit write/read register port. The intended sequence is as follows. First clear the enable register. Then write the mask/identifier pairs. Then set the enable bits. A slot's pair cannot be changed while that slot is enabled, so a live comparison never sees a half-written filter.

Top module: `rx_id_screen`

## Requirements
- R1: After reset, every enable, mask and identifier register reads 0, and `rx_accept`, `rx_hit` and `rx_hit_idx` are 0.
- R2: The enable register is at offset 0x60. Bit i enables slot i (bits 3:0 for four slots). Writes to it always take effect, and bits above the slot count read back as 0.
- R3: Slot i (i = 0..3) has its mask at offset 0x64 + 8*i and its identifier at offset 0x68 + 8*i. Both read back the value last stored.
- R4: Slot i matches when (`rx_word` AND mask_i) equals (identifier_i AND mask_i) over all 32 bits. A mask of 0 therefore matches every word.
- R5: A word is accepted when at least one enabled slot matches it. A slot whose enable bit is 0 never causes an acceptance.
- R6: While the enable register holds 0, every word is accepted, with `rx_hit` = 0 and `rx_hit_idx` = 0.
- R7: When slots are enabled but none of them matches, no accept pulse is produced, and `rx_hit` and `rx_hit_idx` stay 0.
- R8: A write to a slot's mask or identifier is ignored while that slot's enable bit is 1. A write to a disabled slot takes effect.
- R9: When several enabled slots match, `rx_hit` = 1 and `rx_hit_idx` gives the lowest matching slot number.
- R10: The verdict for a word presented with `rx_valid` = 1 appears on the outputs in the following cycle only, once per valid cycle, even for back-to-back words. The comparison uses the register contents from before any register write made in the same cycle.
- R11: Offsets that are not mapped read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset for writes and reads |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| rx_valid | input | 1 | Identifier word present this cycle |
| rx_word | input | 32 | Received identifier word |
| rx_accept | output | 1 | One-cycle pulse: store the frame |
| rx_hit | output | 1 | Acceptance came from a matching slot |
| rx_hit_idx | output | 2 | Lowest matching slot number |

## Verification
A corrupted mask, identifier or enable bit changes the verdict on the accept pulse one cycle after the next word that reaches the affected slot. The register read port shows the same fault at once, without waiting for a word. A wrong lock condition shows as a read-back that differs from the protected value right after the rejected write. A priority or timing fault shows on the cycle right after the valid word, as a wrong index or as a pulse that lasts too long or is missing.

// File: rtl/rx_id_screen_pkg.sv
package rx_id_screen_pkg;
    localparam int unsigned SCR_NF = 4;
    localparam int unsigned SCR_IW = 32;
    localparam int unsigned SCR_AW = 8;
    localparam int unsigned SCR_XW = (SCR_NF > 1) ? $clog2(SCR_NF) : 1;

    typedef logic [SCR_IW-1:0] word_t;
    typedef logic [SCR_NF-1:0] fvec_t;
    typedef logic [SCR_XW-1:0] fidx_t;
    typedef logic [SCR_AW-1:0] addr_t;

    typedef struct packed {
        fvec_t                 en;
        word_t [SCR_NF-1:0]    mask;
        word_t [SCR_NF-1:0]    idv;
    } bank_t;

    typedef struct packed {
        logic  accept;
        logic  hit;
        fidx_t idx;
    } verdict_t;
endpackage

// File: rtl/screen_bank.sv
module screen_bank
    import rx_id_screen_pkg::*;
#(
    parameter int unsigned BASE_OFF = 32'h60
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  addr_t              addr,
    input  word_t              wdata,
    output word_t              rdata,
    output fvec_t              en,
    output word_t [SCR_NF-1:0] mask,
    output word_t [SCR_NF-1:0] idv
);
    function automatic addr_t mask_off(input int unsigned i);
        return addr_t'(BASE_OFF + 4 + 8 * i);
    endfunction

    function automatic addr_t id_off(input int unsigned i);
        return addr_t'(BASE_OFF + 8 + 8 * i);
    endfunction

    localparam addr_t EN_OFF = addr_t'(BASE_OFF);

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        rdata  = '0;
        if (wr) begin
            if (addr == EN_OFF) begin
                bank_d.en = wdata[SCR_NF-1:0];
            end
            for (int unsigned i = 0; i < SCR_NF; i++) begin
                if (!bank_q.en[i] && addr == mask_off(i)) begin
                    bank_d.mask[i] = wdata;
                end
                if (!bank_q.en[i] && addr == id_off(i)) begin
                    bank_d.idv[i] = wdata;
                end
            end
        end
        if (addr == EN_OFF) begin
            rdata = word_t'(bank_q.en);
        end
        for (int unsigned i = 0; i < SCR_NF; i++) begin
            if (addr == mask_off(i)) rdata = bank_q.mask[i];
            if (addr == id_off(i))   rdata = bank_q.idv[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign en   = bank_q.en;
    assign mask = bank_q.mask;
    assign idv  = bank_q.idv;

    for (genvar g = 0; g < SCR_NF; g++) begin : g_lock_chk
        // R8: an enabled slot keeps its pair across a write
        a_r8_mask_locked: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr == mask_off(g) && bank_q.en[g]) |=> $stable(bank_q.mask[g]));
        a_r8_id_locked: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr == id_off(g) && bank_q.en[g]) |=> $stable(bank_q.idv[g]));
    end
endmodule

// File: rtl/screen_compare.sv
module screen_compare
    import rx_id_screen_pkg::*;
(
    input  word_t              word,
    input  fvec_t              en,
    input  word_t [SCR_NF-1:0] mask,
    input  word_t [SCR_NF-1:0] idv,
    output fvec_t              hits
);
    for (genvar g = 0; g < SCR_NF; g++) begin : g_slot
        assign hits[g] = en[g] && (((word ^ idv[g]) & mask[g]) == '0);
    end
endmodule

// File: rtl/screen_pick.sv
module screen_pick
    import rx_id_screen_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  valid,
    input  fvec_t en,
    input  fvec_t hits,
    output logic  accept,
    output logic  hit,
    output fidx_t idx
);
    verdict_t vrd_d, vrd_q;

    always_comb begin
        vrd_d        = '0;
        vrd_d.hit    = valid && (hits != '0);
        vrd_d.accept = valid && ((en == '0) || (hits != '0));
        if (vrd_d.hit) begin
            for (int i = SCR_NF - 1; i >= 0; i--) begin
                if (hits[i]) vrd_d.idx = fidx_t'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vrd_q <= '0;
        else        vrd_q <= vrd_d;
    end

    assign accept = vrd_q.accept;
    assign hit    = vrd_q.hit;
    assign idx    = vrd_q.idx;

    a_r10_no_idle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid) |-> !accept);
    a_r6_pass_all: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && en == '0) |=> (accept && !hit));
    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && en != '0 && hits == '0) |=> (!accept && !hit));
endmodule

// File: rtl/rx_id_screen.sv
module rx_id_screen
    import rx_id_screen_pkg::*;
#(
    parameter int unsigned BASE_OFF = 32'h60
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [SCR_AW-1:0]   cfg_addr,
    input  logic [SCR_IW-1:0]   cfg_wdata,
    output logic [SCR_IW-1:0]   cfg_rdata,
    input  logic                rx_valid,
    input  logic [SCR_IW-1:0]   rx_word,
    output logic                rx_accept,
    output logic                rx_hit,
    output logic [SCR_XW-1:0]   rx_hit_idx
);
    fvec_t              en;
    word_t [SCR_NF-1:0] mask;
    word_t [SCR_NF-1:0] idv;
    fvec_t              hits;

    screen_bank #(.BASE_OFF(BASE_OFF)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .en    (en),
        .mask  (mask),
        .idv   (idv)
    );

    screen_compare u_cmp (
        .word (rx_word),
        .en   (en),
        .mask (mask),
        .idv  (idv),
        .hits (hits)
    );

    screen_pick u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (rx_valid),
        .en     (en),
        .hits   (hits),
        .accept (rx_accept),
        .hit    (rx_hit),
        .idx    (rx_hit_idx)
    );

    // R9: the reported slot matched and no lower slot did
    a_r9_lowest_slot: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hit |-> (((($past(hits) >> rx_hit_idx) & fvec_t'(1)) != '0) &&
                    (($past(hits) & ((fvec_t'(1) << rx_hit_idx) - fvec_t'(1))) == '0)));
    // R5: an enabled match always produces an accepted, matched verdict
    a_r5_match_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && hits != '0) |=> (rx_accept && rx_hit));
endmodule

// File: tb/rx_id_screen_test.sv
module rx_id_screen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_word = '0;
    logic        rx_accept;
    logic        rx_hit;
    logic [1:0]  rx_hit_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_id_screen uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_valid(rx_valid),
        .rx_word(rx_word), .rx_accept(rx_accept), .rx_hit(rx_hit),
        .rx_hit_idx(rx_hit_idx)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string rq);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(rq, cfg_rdata, exp);
    endtask

    task automatic send(input logic [31:0] w, input logic ea, input logic eh,
                        input logic [1:0] ei, input string rq);
        @(negedge clk);
        rx_valid = 1'b1; rx_word = w;
        @(negedge clk);
        rx_valid = 1'b0;
        chk({rq, " accept"}, 32'(rx_accept), 32'(ea));
        chk({rq, " hit"},    32'(rx_hit),    32'(eh));
        chk({rq, " index"},  32'(rx_hit_idx), 32'(ei));
        @(negedge clk);
        chk({rq, " pulse ends"}, 32'(rx_accept), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 accept", 32'(rx_accept), 32'd0);
        chk("R1 hit", 32'(rx_hit), 32'd0);
        rd_chk(8'h60, 32'h0, "R1 enable");
        rd_chk(8'h64, 32'h0, "R1 mask0");
        rd_chk(8'h80, 32'h0, "R1 id3");
    endtask

    task automatic t_pass_all();
        send(32'h14, 1'b1, 1'b0, 2'd0, "R6");
    endtask

    task automatic t_program();
        wr_reg(8'h60, 32'h0);
        wr_reg(8'h64, 32'hF7);   wr_reg(8'h68, 32'h121F);
        wr_reg(8'h6C, 32'h5431); wr_reg(8'h70, 32'h14);
        wr_reg(8'h74, 32'h1234); wr_reg(8'h78, 32'h5431);
        wr_reg(8'h7C, 32'hFFF);  wr_reg(8'h80, 32'h1234);
        wr_reg(8'h60, 32'hF);
        rd_chk(8'h6C, 32'h5431, "R3 mask1");
        rd_chk(8'h78, 32'h5431, "R3 id2");
        send(32'h14,   1'b1, 1'b1, 2'd1, "R4 slot1");
        send(32'h1234, 1'b1, 1'b1, 2'd3, "R4 slot3");
        send(32'h0,    1'b0, 1'b0, 2'd0, "R7");
    endtask

    task automatic t_disabled();
        wr_reg(8'h60, 32'h8);
        send(32'h14,   1'b0, 1'b0, 2'd0, "R5 disabled slot");
        send(32'h1234, 1'b1, 1'b1, 2'd3, "R5 enabled slot");
    endtask

    task automatic t_lock();
        wr_reg(8'h7C, 32'h0);
        rd_chk(8'h7C, 32'hFFF, "R8 locked mask");
        wr_reg(8'h80, 32'h14);
        rd_chk(8'h80, 32'h1234, "R8 locked id");
        wr_reg(8'h64, 32'h1);
        rd_chk(8'h64, 32'h1, "R8 open slot");
        send(32'h14, 1'b0, 1'b0, 2'd0, "R8 verdict");
    endtask

    task automatic t_lowest();
        wr_reg(8'h60, 32'h0);
        wr_reg(8'h74, 32'h0);
        wr_reg(8'h60, 32'hC);
        send(32'h1234, 1'b1, 1'b1, 2'd2, "R9 two match");
        send(32'h0,    1'b1, 1'b1, 2'd2, "R9 one match");
    endtask

    task automatic t_en_width();
        wr_reg(8'h60, 32'hFFFF_FFF3);
        rd_chk(8'h60, 32'h3, "R2 enable width");
    endtask

    task automatic t_unmapped();
        wr_reg(8'h90, 32'hDEAD_BEEF);
        rd_chk(8'h90, 32'h0, "R11 unmapped read");
        rd_chk(8'h60, 32'h3, "R11 enable untouched");
    endtask

    task automatic t_same_cycle();
        wr_reg(8'h60, 32'h8);
        @(negedge clk);
        rx_valid = 1'b1; rx_word = 32'h14;
        cfg_wr = 1'b1; cfg_addr = 8'h60; cfg_wdata = 32'h0;
        @(negedge clk);
        rx_valid = 1'b0; cfg_wr = 1'b0;
        chk("R10 old registers used", 32'(rx_accept), 32'd0);
        send(32'h14, 1'b1, 1'b0, 2'd0, "R10 new registers");
    endtask

    task automatic t_back_to_back();
        wr_reg(8'h60, 32'h8);
        @(negedge clk);
        rx_valid = 1'b1; rx_word = 32'h1234;
        @(negedge clk);
        rx_word = 32'h0;
        chk("R10 first accept", 32'(rx_accept), 32'd1);
        chk("R10 first index", 32'(rx_hit_idx), 32'd3);
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R10 second dropped", 32'(rx_accept), 32'd0);
        @(negedge clk);
        chk("R10 idle", 32'(rx_accept), 32'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pass_all();
        t_program();
        t_disabled();
        t_lock();
        t_lowest();
        t_en_width();
        t_unmapped();
        t_same_cycle();
        t_back_to_back();
        done = 1'b1;
        summary();
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end
endmodule